// File: doc/BRIEF.md
# Command Queue Sequencer and Decoder

This block sits behind the command window of a crypto engine. Software writes 32-bit words one at a time; the block collects them in a nine-word staging buffer and, after each accepted word, tries to run the command held in the first entry. If the command still lacks payload words, the buffer is kept and the command is tried again after the next word arrives. When a command completes, the buffer is emptied, so the next word starts a new command.

Key loads, IV loads and flags are reported as one-cycle strobes that carry the decoded fields. Data-transfer and store-IV commands are presented as descriptors with a valid/ready handshake toward a downstream DMA and cipher engine. The buffer is held until the descriptor is accepted, and the write port stalls while the descriptor waits. Opcodes the block does not know raise a one-cycle invalid-command strobe and leave the buffer untouched.

Top module: `cmdq_sequencer`

## Requirements
- R1: The opcode is bits 31:28 of buffer entry 0. Opcode 8 (flag) completes with no payload: `flag_stb` pulses, `flag_irq` equals bit 27 of the word and `flag_info` equals bits 7:0.
- R2: The buffer holds at most 9 words. A word written while it is full is discarded with no error indication, `wr_ready` stays high, and no strobe or descriptor results.
- R3: While a command lacks payload words, no strobe or descriptor is produced and the buffered words are kept, so later appends complete it.
- R4: Once a command completes (strobe issued, or descriptor accepted), the buffer is empty and the next word written is decoded as a new command.
- R5: Any opcode other than 1, 2, 5, 6 and 8 pulses `bad_cmd_stb` after each append and does not clear the buffer.
- R6: A key command (opcode 1) with a nonzero select field (bits 26:24) completes with no payload and reports `key_data` as zero. Other fields: context bit 27, length code 23:22, encrypt bit 20, mode 17:16 (0 = ECB, 1 = CBC, reported on `key_cbc`).
- R7: A key command with select 0 needs 4, 6 or 8 payload words for length codes 0, 1 or 2. Payload word k+1 appears at `key_data[32k+31:32k]` and unused words read as zero. Length code 3 never completes.
- R8: A key command whose mode field is 2 or 3 never completes, whatever its payload.
- R9: Opcode 2 (IV) needs 4 payload words. `iv_ctx` is bits 27:26, and payload word k+1 appears at `iv_data[32k+31:32k]`.
- R10: Opcode 5 (data) needs 3 payload words. `dat_len` is bits 23:0 and `dat_key_ctx` is bit 27. `dat_src` is {payload1[31:16], payload2} and `dat_dst` is {payload1[15:0], payload3}.
- R11: Opcode 6 (store IV) needs 1 payload word. `siv_ctx` is bits 27:26 and `siv_addr` is {cmd[7:0], payload1}.
- R12: A descriptor stays valid with stable fields until its ready is high at a clock edge. `wr_ready` is low while any descriptor is valid.
- R13: The result of an append appears in the second cycle after the edge that accepted the word: strobes last one cycle and descriptors become valid. `wr_ready` is low in the cycle after each accepted word. After reset all strobes and valids are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Command word offered |
| wr_data | input | 32 | Command word |
| wr_ready | output | 1 | Word is accepted when high with wr_valid |
| key_stb | output | 1 | Key load completed |
| key_ctx | output | 1 | Key context |
| key_sel | output | 3 | Built-in key select (0 = loaded key) |
| key_len_code | output | 2 | Key length code |
| key_enc | output | 1 | Encrypt direction |
| key_cbc | output | 1 | Chained mode (0 = ECB) |
| key_data | output | 256 | Loaded key words |
| iv_stb | output | 1 | IV load completed |
| iv_ctx | output | 2 | IV context |
| iv_data | output | 128 | IV words |
| flag_stb | output | 1 | Flag command completed |
| flag_irq | output | 1 | Flag requests an interrupt |
| flag_info | output | 8 | Flag info byte |
| bad_cmd_stb | output | 1 | Invalid opcode seen |
| dat_valid | output | 1 | Data descriptor valid |
| dat_ready | input | 1 | Data descriptor accepted |
| dat_key_ctx | output | 1 | Key context for the transfer |
| dat_len | output | 24 | Transfer length in bytes |
| dat_src | output | 48 | Source address |
| dat_dst | output | 48 | Destination address |
| siv_valid | output | 1 | Store-IV descriptor valid |
| siv_ready | input | 1 | Store-IV descriptor accepted |
| siv_ctx | output | 2 | IV context to store |
| siv_addr | output | 40 | Store target address |

## Verification
The assertions assume that `dat_ready` and `siv_ready` are single-bit levels sampled only while their valid is high. They also assume `wr_valid` is honoured only when `wr_ready` is high, which the bench enforces by waiting on `wr_ready` before it presents each word. Random command streams are built from well-formed commands of every opcode, interleaved with junk words that may be invalid or never complete. Whenever such a word leaves the buffer occupied, the bench resets the block, so every sequence starts from an empty buffer. Directed cases cover filling the buffer past nine words, unsupported key length and mode codes, and an invalid opcode followed by more writes.

// File: rtl/cmdq_pkg.sv
// Package: shared constants, opcode and verdict types for the command queue.
// Assumes 32-bit command words with the opcode in the top nibble.
package cmdq_pkg;
    localparam int WORD_W     = 32;
    localparam int KEY_WORDS  = 8;
    localparam int IV_WORDS   = 4;
    localparam int DATA_WORDS = 3;
    localparam int SIV_WORDS  = 1;
    localparam int LEN_W      = 24;
    localparam int ADDR_W     = 48;
    localparam int SIV_ADDR_W = 40;
    localparam int INFO_W     = 8;
    localparam int KEY_W      = KEY_WORDS * WORD_W;
    localparam int IV_W       = IV_WORDS * WORD_W;
    localparam logic [3:0] NEED_NONE = 4'hF;

    typedef enum logic [3:0] {
        OPC_KEY  = 4'h1,
        OPC_IV   = 4'h2,
        OPC_DATA = 4'h5,
        OPC_SIV  = 4'h6,
        OPC_FLAG = 4'h8
    } opcode_e;

    typedef enum logic [2:0] {
        V_WAIT, V_KEY, V_IV, V_DATA, V_SIV, V_FLAG, V_BAD
    } verdict_e;

    // Payload words a key command needs; NEED_NONE marks an unusable length code.
    function automatic logic [3:0] key_need(input logic [2:0] sel, input logic [1:0] code);
        logic [3:0] n;
        if (sel != 3'd0) begin
            n = 4'd0;
        end else begin
            case (code)
                2'd0:    n = 4'd4;
                2'd1:    n = 4'd6;
                2'd2:    n = 4'd8;
                default: n = NEED_NONE;
            endcase
        end
        return n;
    endfunction
endpackage

// File: rtl/cmdq_store.sv
// Module: cmdq_store
// Staging buffer of DEPTH command words with a write count. Appends go to
// entry [count]; an append at full count is dropped. A clear empties it.
// Assumes push and clr are never high together.
module cmdq_store
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 9,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [WORD_W-1:0]             din,
    input  logic                          clr,
    output logic [DEPTH-1:0][WORD_W-1:0]  words,
    output logic [CNT_W-1:0]              count
);
    logic full;
    assign full = (count == CNT_W'(DEPTH));

    // Track the number of buffered words.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (clr)              count <= '0;
        else if (push && !full)    count <= count + 1'b1;
    end

    // One register per entry, written when it is the next free slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (push && !clr && count == CNT_W'(i))
                words[i] <= din;
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> (count == CNT_W'(DEPTH)) && $stable(words));
endmodule

// File: rtl/cmdq_decode.sv
// Module: cmdq_decode
// Combinational decode of the buffered command: decides whether it is
// complete, invalid or still waiting, and extracts every output field.
// Assumes DEPTH >= KEY_WORDS + 1 so the longest key fits.
module cmdq_decode
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 9,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][WORD_W-1:0] words,
    input  logic [CNT_W-1:0]             count,
    output verdict_e                     verdict,
    output logic                         key_ctx,
    output logic [2:0]                   key_sel,
    output logic [1:0]                   key_len_code,
    output logic                         key_enc,
    output logic                         key_cbc,
    output logic [KEY_W-1:0]             key_data,
    output logic [1:0]                   iv_ctx,
    output logic [IV_W-1:0]              iv_data,
    output logic                         dat_key_ctx,
    output logic [LEN_W-1:0]             dat_len,
    output logic [ADDR_W-1:0]            dat_src,
    output logic [ADDR_W-1:0]            dat_dst,
    output logic [1:0]                   siv_ctx,
    output logic [SIV_ADDR_W-1:0]        siv_addr,
    output logic                         flag_irq,
    output logic [INFO_W-1:0]            flag_info
);
    logic [WORD_W-1:0] cmd;
    logic [3:0]        need;
    logic [3:0]        need_eff;
    int                have;

    assign cmd          = words[0];
    assign key_ctx      = cmd[27];
    assign key_sel      = cmd[26:24];
    assign key_len_code = cmd[23:22];
    assign key_enc      = cmd[20];
    assign key_cbc      = cmd[16];
    assign need         = key_need(key_sel, key_len_code);
    assign need_eff     = (need == NEED_NONE) ? 4'd0 : need;
    assign have         = int'(count) - 1;

    // Key payload words, zero beyond the length in use.
    for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
        assign key_data[k*WORD_W +: WORD_W] = (k < int'(need_eff)) ? words[k+1] : '0;
    end

    // IV payload words in arrival order.
    for (genvar k = 0; k < IV_WORDS; k++) begin : g_iv
        assign iv_data[k*WORD_W +: WORD_W] = words[k+1];
    end

    assign iv_ctx      = cmd[27:26];
    assign dat_key_ctx = cmd[27];
    assign dat_len     = cmd[LEN_W-1:0];
    assign dat_src     = {words[1][31:16], words[2]};
    assign dat_dst     = {words[1][15:0],  words[3]};
    assign siv_ctx     = cmd[27:26];
    assign siv_addr    = {cmd[7:0], words[1]};
    assign flag_irq    = cmd[27];
    assign flag_info   = cmd[INFO_W-1:0];

    // Classify the command in entry 0 against the payload present.
    always_comb begin
        verdict = V_WAIT;
        case (opcode_e'(cmd[31:28]))
            OPC_KEY:  if (cmd[17] == 1'b0 && need != NEED_NONE && have >= int'(need))
                          verdict = V_KEY;
            OPC_IV:   if (have >= IV_WORDS)   verdict = V_IV;
            OPC_DATA: if (have >= DATA_WORDS) verdict = V_DATA;
            OPC_SIV:  if (have >= SIV_WORDS)  verdict = V_SIV;
            OPC_FLAG: verdict = V_FLAG;
            default:  verdict = V_BAD;
        endcase
    end
endmodule

// File: rtl/cmdq_sequencer.sv
// Module: cmdq_sequencer (top)
// Accepts command words, evaluates the buffered command one cycle after each
// accepted word, issues one-cycle strobes or holds descriptors until accepted,
// and empties the buffer when a command completes.
// Assumes downstream readiness is sampled only while the matching valid is high.
module cmdq_sequencer
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [WORD_W-1:0]       wr_data,
    output logic                    wr_ready,
    output logic                    key_stb,
    output logic                    key_ctx,
    output logic [2:0]              key_sel,
    output logic [1:0]              key_len_code,
    output logic                    key_enc,
    output logic                    key_cbc,
    output logic [KEY_W-1:0]        key_data,
    output logic                    iv_stb,
    output logic [1:0]              iv_ctx,
    output logic [IV_W-1:0]         iv_data,
    output logic                    flag_stb,
    output logic                    flag_irq,
    output logic [INFO_W-1:0]       flag_info,
    output logic                    bad_cmd_stb,
    output logic                    dat_valid,
    input  logic                    dat_ready,
    output logic                    dat_key_ctx,
    output logic [LEN_W-1:0]        dat_len,
    output logic [ADDR_W-1:0]       dat_src,
    output logic [ADDR_W-1:0]       dat_dst,
    output logic                    siv_valid,
    input  logic                    siv_ready,
    output logic [1:0]              siv_ctx,
    output logic [SIV_ADDR_W-1:0]   siv_addr
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][WORD_W-1:0] words;
    logic [CNT_W-1:0]             count;
    logic                         push, clr, eval_q;
    verdict_e                     verdict;

    logic                  d_key_ctx, d_key_enc, d_key_cbc;
    logic [2:0]            d_key_sel;
    logic [1:0]            d_key_len_code, d_iv_ctx, d_siv_ctx;
    logic [KEY_W-1:0]      d_key_data;
    logic [IV_W-1:0]       d_iv_data;
    logic                  d_dat_key_ctx, d_flag_irq;
    logic [LEN_W-1:0]      d_dat_len;
    logic [ADDR_W-1:0]     d_dat_src, d_dat_dst;
    logic [SIV_ADDR_W-1:0] d_siv_addr;
    logic [INFO_W-1:0]     d_flag_info;

    logic fire_key, fire_iv, fire_dat, fire_siv, fire_flag, fire_bad;
    logic dat_take, siv_take;

    assign wr_ready  = !eval_q && !dat_valid && !siv_valid;
    assign push      = wr_valid && wr_ready;
    assign fire_key  = eval_q && verdict == V_KEY;
    assign fire_iv   = eval_q && verdict == V_IV;
    assign fire_dat  = eval_q && verdict == V_DATA;
    assign fire_siv  = eval_q && verdict == V_SIV;
    assign fire_flag = eval_q && verdict == V_FLAG;
    assign fire_bad  = eval_q && verdict == V_BAD;
    assign dat_take  = dat_valid && dat_ready;
    assign siv_take  = siv_valid && siv_ready;
    assign clr       = fire_key || fire_iv || fire_flag || dat_take || siv_take;

    cmdq_store #(.DEPTH(DEPTH)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (wr_data),
        .clr   (clr),
        .words (words),
        .count (count)
    );

    cmdq_decode #(.DEPTH(DEPTH)) i_decode (
        .words        (words),
        .count        (count),
        .verdict      (verdict),
        .key_ctx      (d_key_ctx),
        .key_sel      (d_key_sel),
        .key_len_code (d_key_len_code),
        .key_enc      (d_key_enc),
        .key_cbc      (d_key_cbc),
        .key_data     (d_key_data),
        .iv_ctx       (d_iv_ctx),
        .iv_data      (d_iv_data),
        .dat_key_ctx  (d_dat_key_ctx),
        .dat_len      (d_dat_len),
        .dat_src      (d_dat_src),
        .dat_dst      (d_dat_dst),
        .siv_ctx      (d_siv_ctx),
        .siv_addr     (d_siv_addr),
        .flag_irq     (d_flag_irq),
        .flag_info    (d_flag_info)
    );

    // Schedule an evaluation in the cycle after every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) eval_q <= 1'b0;
        else        eval_q <= push;
    end

    // One-cycle strobes for the commands that complete in place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_stb     <= 1'b0;
            iv_stb      <= 1'b0;
            flag_stb    <= 1'b0;
            bad_cmd_stb <= 1'b0;
        end else begin
            key_stb     <= fire_key;
            iv_stb      <= fire_iv;
            flag_stb    <= fire_flag;
            bad_cmd_stb <= fire_bad;
        end
    end

    // Capture key fields when a key command completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_ctx <= 1'b0; key_sel <= '0; key_len_code <= '0;
            key_enc <= 1'b0; key_cbc <= 1'b0; key_data <= '0;
        end else if (fire_key) begin
            key_ctx <= d_key_ctx; key_sel <= d_key_sel; key_len_code <= d_key_len_code;
            key_enc <= d_key_enc; key_cbc <= d_key_cbc; key_data <= d_key_data;
        end
    end

    // Capture IV and flag fields when those commands complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_ctx <= '0; iv_data <= '0; flag_irq <= 1'b0; flag_info <= '0;
        end else begin
            if (fire_iv)   begin iv_ctx <= d_iv_ctx; iv_data <= d_iv_data; end
            if (fire_flag) begin flag_irq <= d_flag_irq; flag_info <= d_flag_info; end
        end
    end

    // Data descriptor: raise on completion, drop on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_valid <= 1'b0; dat_key_ctx <= 1'b0; dat_len <= '0;
            dat_src <= '0; dat_dst <= '0;
        end else if (fire_dat) begin
            dat_valid <= 1'b1; dat_key_ctx <= d_dat_key_ctx; dat_len <= d_dat_len;
            dat_src <= d_dat_src; dat_dst <= d_dat_dst;
        end else if (dat_take) begin
            dat_valid <= 1'b0;
        end
    end

    // Store-IV descriptor: raise on completion, drop on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            siv_valid <= 1'b0; siv_ctx <= '0; siv_addr <= '0;
        end else if (fire_siv) begin
            siv_valid <= 1'b1; siv_ctx <= d_siv_ctx; siv_addr <= d_siv_addr;
        end else if (siv_take) begin
            siv_valid <= 1'b0;
        end
    end

    // R12
    dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && !dat_ready) |=> dat_valid && $stable(dat_src) && $stable(dat_dst)
                                      && $stable(dat_len) && $stable(dat_key_ctx));
    // R12
    siv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (siv_valid && !siv_ready) |=> siv_valid && $stable(siv_addr) && $stable(siv_ctx));
    // R12
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid || siv_valid) |-> !wr_ready);
    // R13
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({key_stb, iv_stb, flag_stb, bad_cmd_stb, dat_valid, siv_valid}));
    // R13
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_stb || iv_stb || flag_stb || bad_cmd_stb) |=> !(key_stb || iv_stb || flag_stb || bad_cmd_stb));
    // R4
    clear_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_stb || iv_stb || flag_stb) |-> count == '0);
    // R3
    wait_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_q && verdict == V_WAIT) |=> count == $past(count));
    // R5
    bad_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_q && verdict == V_BAD) |=> count == $past(count) && bad_cmd_stb);
endmodule

// File: tb/test_cmdq_sequencer.sv
// Bench: random and directed command streams against a bench-side model.
module test_cmdq_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_valid = 1'b0, wr_ready;
    logic [31:0] wr_data = '0;
    logic key_stb, key_ctx, key_enc, key_cbc;
    logic [2:0] key_sel;
    logic [1:0] key_len_code, iv_ctx, siv_ctx;
    logic [255:0] key_data;
    logic iv_stb;
    logic [127:0] iv_data;
    logic flag_stb, flag_irq, bad_cmd_stb;
    logic [7:0] flag_info;
    logic dat_valid, dat_ready = 1'b0, dat_key_ctx;
    logic [23:0] dat_len;
    logic [47:0] dat_src, dat_dst;
    logic siv_valid, siv_ready = 1'b0;
    logic [39:0] siv_addr;

    cmdq_sequencer #(.DEPTH(DEPTH)) i_cmdq_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .key_stb(key_stb), .key_ctx(key_ctx), .key_sel(key_sel), .key_len_code(key_len_code),
        .key_enc(key_enc), .key_cbc(key_cbc), .key_data(key_data),
        .iv_stb(iv_stb), .iv_ctx(iv_ctx), .iv_data(iv_data),
        .flag_stb(flag_stb), .flag_irq(flag_irq), .flag_info(flag_info), .bad_cmd_stb(bad_cmd_stb),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_key_ctx(dat_key_ctx), .dat_len(dat_len),
        .dat_src(dat_src), .dat_dst(dat_dst),
        .siv_valid(siv_valid), .siv_ready(siv_ready), .siv_ctx(siv_ctx), .siv_addr(siv_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nfail = 0;
    logic [31:0] mbuf [DEPTH];
    int mcnt = 0;

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Expected outcome from the requirements: 0 wait,1 key,2 iv,3 data,4 store-IV,5 flag,6 bad.
    task automatic model_eval(output int v, output logic [255:0] ea, output logic [255:0] eb);
        logic [31:0] c;
        int need;
        c = mbuf[0]; v = 0; ea = '0; eb = '0;
        case (c[31:28])
            4'h1: begin
                if (c[26:24] != 3'd0) need = 0;
                else if (c[23:22] == 2'd0) need = 4;
                else if (c[23:22] == 2'd1) need = 6;
                else if (c[23:22] == 2'd2) need = 8;
                else need = -1;
                if (c[17:16] <= 2'd1 && need >= 0 && mcnt >= need + 1) begin
                    v = 1;
                    ea = {c[27], c[26:24], c[23:22], c[20], c[16]};
                    for (int k = 0; k < 8; k++) if (k < need) eb[k*32 +: 32] = mbuf[k+1];
                end
            end
            4'h2: if (mcnt >= 5) begin v = 2; ea = {c[27:26], mbuf[4], mbuf[3], mbuf[2], mbuf[1]}; end
            4'h5: if (mcnt >= 4) begin
                v = 3; ea = {c[27], c[23:0], mbuf[1][31:16], mbuf[2], mbuf[1][15:0], mbuf[3]};
            end
            4'h6: if (mcnt >= 2) begin v = 4; ea = {c[27:26], c[7:0], mbuf[1]}; end
            4'h8: begin v = 5; ea = {c[27], c[7:0]}; end
            default: v = 6;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_valid = 1'b0; dat_ready = 1'b0; siv_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; mcnt = 0;
        @(negedge clk);
    endtask

    // Present one word, then check the outcome in the second cycle after acceptance.
    task automatic push(input logic [31:0] w);
        int v, k;
        logic [255:0] ea, eb, held;
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1; wr_data = w;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R13 wr_ready low after accept", wr_ready, 0);
        if (mcnt < DEPTH) begin mbuf[mcnt] = w; mcnt++; end
        model_eval(v, ea, eb);
        @(negedge clk);
        chk("R1 R3 R5 R13 outcome strobes", {key_stb, iv_stb, dat_valid, siv_valid, flag_stb, bad_cmd_stb},
            {v == 1, v == 2, v == 3, v == 4, v == 5, v == 6});
        case (v)
            1: begin
                chk("R6 key fields", {key_ctx, key_sel, key_len_code, key_enc, key_cbc}, ea);
                chk("R7 key data", key_data, eb);
                mcnt = 0;
            end
            2: begin chk("R9 iv fields", {iv_ctx, iv_data}, ea); mcnt = 0; end
            5: begin chk("R1 flag fields", {flag_irq, flag_info}, ea); mcnt = 0; end
            3, 4: begin
                held = (v == 3) ? {dat_key_ctx, dat_len, dat_src, dat_dst} : {siv_ctx, siv_addr};
                chk(v == 3 ? "R10 data descriptor" : "R11 store-IV descriptor", held, ea);
                k = $urandom_range(0, 3);
                for (int i = 0; i < k; i++) begin
                    @(negedge clk);
                    chk("R12 descriptor held", {dat_valid, siv_valid, wr_ready}, {v == 3, v == 4, 1'b0});
                    chk("R12 descriptor stable",
                        (v == 3) ? {dat_key_ctx, dat_len, dat_src, dat_dst} : {siv_ctx, siv_addr}, ea);
                end
                if (v == 3) dat_ready = 1'b1; else siv_ready = 1'b1;
                @(negedge clk);
                dat_ready = 1'b0; siv_ready = 1'b0;
                chk("R12 descriptor released", {dat_valid, siv_valid, wr_ready}, 3'b001);
                mcnt = 0;
            end
            default: ;
        endcase
    endtask

    // One random command of a random kind, sometimes a junk word.
    task automatic gen_cmd();
        int r, n;
        logic [31:0] c;
        r = $urandom_range(0, 99);
        c = $urandom;
        if (r < 15) begin
            c[31:28] = 4'h1; c[17:16] = 2'($urandom_range(0, 1));
            if (c[26:24] == 3'd0) c[26:24] = 3'd5;
            push(c);
        end else if (r < 30) begin
            c[31:28] = 4'h1; c[26:24] = 3'd0; c[17:16] = 2'($urandom_range(0, 1));
            c[23:22] = 2'($urandom_range(0, 2));
            n = (c[23:22] == 2'd0) ? 4 : (c[23:22] == 2'd1) ? 6 : 8;
            push(c);
            for (int i = 0; i < n; i++) push($urandom);
        end else if (r < 45) begin
            c[31:28] = 4'h2; push(c);
            for (int i = 0; i < 4; i++) push($urandom);
        end else if (r < 65) begin
            c[31:28] = 4'h5; push(c);
            for (int i = 0; i < 3; i++) push($urandom);
        end else if (r < 80) begin
            c[31:28] = 4'h6; push(c); push($urandom);
        end else if (r < 93) begin
            c[31:28] = 4'h8; push(c);
        end else begin
            push(c);
            n = $urandom_range(0, 3);
            for (int i = 0; i < n; i++) push($urandom);
        end
        if (mcnt != 0) do_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog R13 act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        do_reset();
        // R13 reset state
        chk("R13 reset outputs", {wr_ready, key_stb, iv_stb, flag_stb, bad_cmd_stb, dat_valid, siv_valid}, 7'b1000000);
        // R1 flag with interrupt request and info byte
        push(32'h8800_00a5);
        push(32'h8000_003c);
        // R4 command after a completed one decodes fresh
        push(32'h6000_0012); push(32'hdead_beef);
        // R10 directed addresses
        push(32'h5800_0100); push(32'h1234_5678); push(32'haaaa_0000); push(32'hbbbb_0000);
        // R8 mode 2 never completes; R2 overflow past nine words
        push(32'h1002_0000);
        for (int i = 0; i < 11; i++) push(32'h100 + i);
        chk("R2 full buffer still ready", wr_ready, 1);
        do_reset();
        // R7 length code 3 with loaded key never completes
        push(32'h10c0_0000);
        for (int i = 0; i < 10; i++) push(32'h200 + i);
        do_reset();
        // R5 invalid opcode keeps buffer: a following flag word is still invalid
        push(32'h3000_0000);
        push(32'h8000_0001);
        chk("R5 buffer kept after invalid", {flag_stb}, 0);
        do_reset();
        // R3 IV built up word by word; R6 builtin key
        push(32'h2c00_0000); push(32'h1); push(32'h2); push(32'h3); push(32'h4);
        push(32'h1f51_0000);
        for (int i = 0; i < 400; i++) gen_cmd();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule